// File: doc/BRIEF.md
# Rounding Fixed-Point Sequential Divider

This block divides two signed fixed-point numbers that share one Q format and returns a quotient in that same format. The dividend is sign-extended to double width and scaled up by 2^FRAC_BITS, so the fractional scaling survives the division. Half the divisor (an arithmetic right shift by one) is then added as a rounding bias. The biased value is divided by the divisor, and the result is cut back to the operand width. The default format is an 8-bit value with 3 fractional bits.

Division is expensive in logic, so the block does not use a single-cycle array. It runs a restoring shift-subtract loop on magnitudes and produces one quotient bit per clock. The sign is applied at the end, which makes the quotient truncate toward zero.

A caller presents the operands and pulses `start` while `busy` is low. The caller then waits for the one-cycle `done` pulse, reads `quotient`, and checks `divZero` to see whether the divisor was zero.

Top module: `qdiv_top`

## Requirements
- R1: After reset, `busy`, `done` and `divZero` are 0 and `quotient` is 0.
- R2: For a nonzero divisor, `quotient` equals the low W bits of `(dividend*2^FRAC_BITS + (divisor >>> 1)) / divisor`. The operands are read as W-bit two's-complement integers, and the arithmetic is done at 2W-bit width.
- R3: The division in R2 truncates toward zero when the operands have opposite or both negative signs. Example: dividend -20, divisor 8 gives -19.
- R4: A result outside the W-bit signed range is not saturated. Only its low W bits are returned.
- R5: For a zero divisor, `divZero` is 1 and no iteration runs. `quotient` is the largest positive value (0x7F by default) when the dividend is zero or positive, and the most negative value (0x80) when the dividend is negative.
- R6: `done` is high for exactly one cycle per accepted start. `quotient` and `divZero` then keep their values until the next accepted start changes them, and `divZero` clears on a start with a nonzero divisor.
- R7: `busy` rises on the edge that accepts `start` when the divisor is nonzero. While `busy` is high, `start` and the operand inputs are ignored.
- R8: With a nonzero divisor, `done` rises on the 2W-th rising edge after the accepting edge. With a zero divisor, `done` rises on the accepting edge itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; taken only while not busy |
| dividend | input | W | Signed Q-format dividend |
| divisor | input | W | Signed Q-format divisor |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle pulse: result valid |
| quotient | output | W | Signed Q-format rounded quotient |
| divZero | output | 1 | Last operation had a zero divisor |

## Verification
The assertions watch the handshake and the iteration on every cycle:
- `done` never lasts two cycles and never overlaps `busy`.
- `busy` only rises after a start.
- The partial remainder stays below the divisor magnitude.
- The captured divisor stays frozen through the loop.
- A zero-divisor request lands on the correct limit value.

Only the bench scenarios can show the arithmetic results: rounding bias, truncation toward zero for each sign mix, wrap-around on overflow, the exact latency, and that a second start during a run leaves the first result intact.

// File: rtl/qdiv_pkg.sv
package qdiv_pkg;

  typedef struct packed {
    logic load;     // capture operands, begin iteration
    logic step;     // one restoring iteration
    logic finish;   // last iteration: apply sign, publish
    logic zeroFin;  // divisor was zero: publish limit value
  } divStrobes_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } divState_e;

endpackage

// File: rtl/qdiv_ctrl.sv
module qdiv_ctrl
  import qdiv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        divisorIsZero,
  output divStrobes_t strb,
  output logic        busy,
  output logic        done
);

  localparam int QW = 2 * W;
  localparam int CW = $clog2(QW);
  localparam logic [CW-1:0] LAST = CW'(QW - 1);

  divState_e stateQ;
  logic [CW-1:0] cntQ;
  logic doneQ;

  always_comb begin
    strb = '0;
    if (stateQ == ST_IDLE && start) begin
      if (divisorIsZero) strb.zeroFin = 1'b1;
      else               strb.load    = 1'b1;
    end
    if (stateQ == ST_RUN) begin
      strb.step = 1'b1;
      if (cntQ == LAST) strb.finish = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= strb.finish | strb.zeroFin;
      if (strb.load) begin
        stateQ <= ST_RUN;
        cntQ   <= '0;
      end else if (strb.step) begin
        cntQ <= cntQ + 1'b1;
        if (strb.finish) stateQ <= ST_IDLE;
      end
    end
  end

  assign busy = (stateQ == ST_RUN);
  assign done = doneQ;

  // R6: result strobe lasts a single cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: completion and activity never overlap
  p_busy_done_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R7: activity only begins from a request
  p_busy_from_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

endmodule

// File: rtl/qdiv_datapath.sv
module qdiv_datapath
  import qdiv_pkg::*;
#(
  parameter int W         = 8,
  parameter int FRAC_BITS = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  divStrobes_t  strb,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         divisorIsZero,
  output logic [W-1:0] quotient,
  output logic         divZero
);

  localparam int QW = 2 * W;
  localparam logic [W-1:0] MAXPOS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINNEG = {1'b1, {(W-1){1'b0}}};

  // Operand preparation: widen, scale, bias
  logic signed [QW-1:0] dividendWide;
  logic signed [QW-1:0] divisorWide;
  logic signed [QW-1:0] numer;
  logic [QW-1:0] numMag;
  logic [W-1:0]  dMag;
  logic          numNeg;

  always_comb begin
    dividendWide = {{W{dividend[W-1]}}, dividend};
    divisorWide  = {{W{divisor[W-1]}}, divisor};
    numer        = (dividendWide <<< FRAC_BITS) + (divisorWide >>> 1);
    numNeg       = numer[QW-1];
    numMag       = numNeg ? -numer : numer;
    dMag         = divisor[W-1] ? -divisor : divisor;
  end

  assign divisorIsZero = (divisor == '0);

  // Iteration registers
  logic [QW-1:0] numQ;
  logic [W:0]    remQ;
  logic [W-1:0]  divMagQ;
  logic          negQ;
  logic [W-1:0]  quoQ;
  logic          zeroQ;

  logic [W:0]    trial;
  logic          geq;
  logic [W:0]    remNext;
  logic [QW-1:0] numNext;
  logic [QW-1:0] signedQ;

  always_comb begin
    trial   = {remQ[W-1:0], numQ[QW-1]};
    geq     = (trial >= {1'b0, divMagQ});
    remNext = geq ? (trial - {1'b0, divMagQ}) : trial;
    numNext = {numQ[QW-2:0], geq};
    signedQ = negQ ? -numNext : numNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      numQ    <= '0;
      remQ    <= '0;
      divMagQ <= '0;
      negQ    <= 1'b0;
      quoQ    <= '0;
      zeroQ   <= 1'b0;
    end else begin
      if (strb.load) begin
        numQ    <= numMag;
        remQ    <= '0;
        divMagQ <= dMag;
        negQ    <= numNeg ^ divisor[W-1];
        zeroQ   <= 1'b0;
      end else if (strb.step) begin
        numQ <= numNext;
        remQ <= remNext;
      end
      if (strb.finish) quoQ <= signedQ[W-1:0];
      if (strb.zeroFin) begin
        quoQ  <= dividend[W-1] ? MINNEG : MAXPOS;
        zeroQ <= 1'b1;
      end
    end
  end

  assign quotient = quoQ;
  assign divZero  = zeroQ;

  // R2: partial remainder always below the divisor magnitude
  p_rem_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |-> (remQ < {1'b0, divMagQ}));

  // R7: captured divisor frozen during the loop
  p_divisor_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && $past(strb.step)) |-> $stable(divMagQ));

  // R5: zero divisor with non-negative dividend gives the positive limit
  p_zero_pos_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.zeroFin && !dividend[W-1]) |=> (quotient == MAXPOS && divZero));

  // R5: zero divisor with negative dividend gives the negative limit
  p_zero_neg_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.zeroFin && dividend[W-1]) |=> (quotient == MINNEG && divZero));

endmodule

// File: rtl/qdiv_top.sv
module qdiv_top
  import qdiv_pkg::*;
#(
  parameter int W         = 8,
  parameter int FRAC_BITS = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic         divZero
);

  divStrobes_t strb;
  logic divisorIsZero;

  qdiv_ctrl #(.W(W)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .start         (start),
    .divisorIsZero (divisorIsZero),
    .strb          (strb),
    .busy          (busy),
    .done          (done)
  );

  qdiv_datapath #(.W(W), .FRAC_BITS(FRAC_BITS)) u_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .dividend      (dividend),
    .divisor       (divisor),
    .divisorIsZero (divisorIsZero),
    .quotient      (quotient),
    .divZero       (divZero)
  );

endmodule

// File: tb/qdiv_top_bench.sv
module qdiv_top_bench;

  localparam int W = 8;
  localparam int NV = 10;

  // {dividend, divisor, expected quotient}
  localparam logic [23:0] VEC [NV] = '{
    {8'd8,    8'd16,   8'd4},    // 1.0/2.0 -> 0.5
    {8'd20,   8'd8,    8'd20},   // 2.5/1.0
    {8'hEC,   8'd8,    8'hED},   // -2.5/1.0 -> -19 (toward zero)
    {8'd10,   8'hE8,   8'hFE},   // 80-12=68 / -24 -> -2
    {8'hF6,   8'hE8,   8'd3},    // -92 / -24 -> 3
    {8'd7,    8'd3,    8'd19},   // 57/3
    {8'd100,  8'd2,    8'h90},   // 801/2=400 wraps
    {8'h80,   8'h80,   8'd8},    // -1088/-128 -> 8
    {8'd127,  8'd1,    8'hF8},   // 1016 wraps
    {8'd0,    8'd5,    8'd0}     // 2/5 -> 0
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic busy, done, divZero;
  logic [W-1:0] quotient;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  qdiv_top #(.W(W), .FRAC_BITS(3)) u_qdiv_top (
    .clk(clk), .rstN(rstN), .start(start), .dividend(dividend),
    .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .divZero(divZero)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issue one request; returns number of falling edges until done seen.
  task automatic runOp(input logic [W-1:0] x, input logic [W-1:0] y, output int lat);
    @(negedge clk);
    dividend = x; divisor = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 quotient", 32'(quotient), 0);
    chk("R1 divZero", 32'(divZero), 0);
    rstN = 1'b1;

    // R2/R3/R4: vector table
    for (int i = 0; i < NV; i++) begin
      runOp(VEC[i][23:16], VEC[i][15:8], lat);
      chk("R2 R3 R4 quotient", 32'(quotient), 32'(VEC[i][7:0]));
      chk("R8 latency", 32'(lat), 32'(2 * W + 1));
      chk("R5 divZero clear", 32'(divZero), 0);
      @(negedge clk);
      chk("R6 done single", 32'(done), 0);
      chk("R6 quotient held", 32'(quotient), 32'(VEC[i][7:0]));
    end

    // R5: zero divisor cases
    runOp(8'd5, 8'd0, lat);
    chk("R5 pos limit", 32'(quotient), 32'h7F);
    chk("R5 flag", 32'(divZero), 1);
    chk("R8 zero latency", 32'(lat), 1);
    @(negedge clk);
    chk("R6 done single zero", 32'(done), 0);
    chk("R6 flag held", 32'(divZero), 1);
    runOp(8'hFD, 8'd0, lat);
    chk("R5 neg limit", 32'(quotient), 32'h80);
    runOp(8'd0, 8'd0, lat);
    chk("R5 zero dividend", 32'(quotient), 32'h7F);

    // R7: busy rises, start and operands ignored while busy
    @(negedge clk);
    dividend = 8'd20; divisor = 8'd8; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7 busy high", 32'(busy), 1);
    chk("R6 flag clears on start", 32'(divZero), 0);
    @(negedge clk);
    dividend = 8'hEC; divisor = 8'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 3;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk("R7 ignored start result", 32'(quotient), 32'd20);
    chk("R7 ignored start flag", 32'(divZero), 0);
    chk("R7 latency unchanged", 32'(lat), 32'(2 * W + 1));
    chk("R7 busy low at done", 32'(busy), 0);
    repeat (3) @(negedge clk);
    chk("R6 no second done", 32'(done), 0);
    chk("R6 quotient stays", 32'(quotient), 32'd20);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule